// File: doc/BRIEF.md
# Protection output controller

This block sits between the qualified fault detectors of a battery-stack protector and its two output pins. It merges five fault flags onto a charge-side and a discharge-side output. The five flags are cell overvoltage, cell undervoltage, a broken sense wire, thermistor overtemperature and an oscillator-health fault. The mapping is uneven. Overvoltage reaches only the charge side and undervoltage only the discharge side. The other three faults reach both sides.

Each output has its own register. That register either follows its fault requests or, when the latch option is chosen, holds the first activation until the next reset. Pin polarity is picked at reset. An active-high output drives its pin at all times. An active-low output pulls its pin low when active and releases it otherwise.

The block also watches a code for the supply-minus-top-cell differential and decides when to enter and leave a fast test mode. The test-mode flag passes through a two-flop synchronizer and is then offered to the delay timers. A single status bit reports FAULT whenever either output is active and NORMAL otherwise.

Top module: `prot_out_ctrl`

## Requirements
- R1: An overvoltage flag sampled high at a clock edge makes the charge output active from that edge on. Overvoltage alone never activates the discharge output.
- R2: An undervoltage flag sampled high at a clock edge makes the discharge output active from that edge on. Undervoltage alone never activates the charge output.
- R3: The open-wire, overtemperature and oscillator-health flags each activate both outputs at the edge where they are sampled high.
- R4: With the latch option off, an output goes inactive at the first edge where none of the flags mapped to it is high. This includes the oscillator-health fault clearing by itself.
- R5: With the latch option on, an output that has become active stays active until reset. The two outputs latch independently, so a latched charge output leaves the discharge output inactive when no discharge fault has occurred.
- R6: With active-high polarity (`pol_high_cfg`=1 at reset), each pin equals its active state and its enable (`*_oe`) is always 1.
- R7: With active-low polarity (`pol_high_cfg`=0 at reset), an active output has pin 0 with enable 1. An inactive output is released: enable 0, pin 1.
- R8: `pol_high_cfg` and `latch_cfg` are sampled only while `rst_n` is low. Changing them after reset has no effect on the outputs.
- R9: `fault_mode` is 1 (FAULT) exactly when at least one output is active, and 0 (NORMAL) otherwise.
- R10: Test mode is armed at the edge where `sup_diff_code` >= ENTER_CODE (default 125, 0.1 V per LSB). It is disarmed at the edge where the code <= EXIT_CODE (default 100). Codes between the two keep the previous state. `test_mode` follows two synchronizer flops later, so it changes at the third edge after the deciding sample.
- R11: After reset both outputs are inactive, `fault_mode` is 0 and `test_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the window that loads the configuration |
| ov_flt | input | 1 | Qualified overvoltage flag |
| uv_flt | input | 1 | Qualified undervoltage flag |
| ow_flt | input | 1 | Qualified open-wire flag |
| ot_flt | input | 1 | Qualified overtemperature flag |
| osc_flt | input | 1 | Oscillator-health flag |
| pol_high_cfg | input | 1 | 1 = active-high outputs, 0 = active-low released outputs; loaded during reset |
| latch_cfg | input | 1 | 1 = hold activations until reset; loaded during reset |
| sup_diff_code | input | DIFF_W | Supply minus top-cell voltage code |
| chg_pin | output | 1 | Charge-side pin level |
| chg_oe | output | 1 | Charge-side pin drive enable |
| dsg_pin | output | 1 | Discharge-side pin level |
| dsg_oe | output | 1 | Discharge-side pin drive enable |
| fault_mode | output | 1 | 1 = FAULT, 0 = NORMAL |
| test_mode | output | 1 | Synchronized test-mode indication for the delay timers |

## Verification
Single-fault patterns on overvoltage and undervoltage show that the mapping is one-sided. Single pulses on the three shared faults show that they reach both outputs. A fault released while the latch is off separates self-clearing from holding. In the latched pass, a charge-only fault followed by a later discharge fault shows that each output latches on its own. The differential code is swept above the entry level, into the band between the levels, to the exit level, and back to exactly the entry level; this tells hysteresis apart from a single threshold and pins down the synchronizer latency. A second reset with the other polarity, plus configuration pins toggled after reset, separates driving from releasing and shows that the configuration is sampled only at reset.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef struct packed {
    logic ov;
    logic uv;
    logic ow;
    logic ot;
    logic osc;
  } flt_t;

  localparam int NUM_OUT = 2;
  localparam int CHG_IDX = 0;
  localparam int DSG_IDX = 1;
endpackage

// File: rtl/prot_fault_map.sv
module prot_fault_map
  import prot_pkg::*;
(
  input  flt_t               flags,
  output logic [NUM_OUT-1:0] req
);
  logic shared;

  always_comb begin
    shared       = flags.ow | flags.ot | flags.osc;
    req[CHG_IDX] = flags.ov | shared;
    req[DSG_IDX] = flags.uv | shared;
  end
endmodule

// File: rtl/prot_out_stage.sv
module prot_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic latch_en,
  input  logic act_high,
  output logic active,
  output logic pin,
  output logic oe
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        act_q <= 1'b0;
    else if (latch_en) act_q <= act_q | req;
    else               act_q <= req;
  end

  always_comb begin
    active = act_q;
    if (act_high) begin
      pin = act_q;
      oe  = 1'b1;
    end else begin
      pin = ~act_q;
      oe  = act_q;
    end
  end
endmodule

// File: rtl/prot_ctm_detect.sv
module prot_ctm_detect #(
  parameter int DIFF_W      = 8,
  parameter int ENTER_CODE  = 125,
  parameter int EXIT_CODE   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIFF_W-1:0] diff_code,
  output logic              test_mode
);
  localparam logic [DIFF_W-1:0] ENTER_V = DIFF_W'(ENTER_CODE);
  localparam logic [DIFF_W-1:0] EXIT_V  = DIFF_W'(EXIT_CODE);

  logic                   armed_q;
  logic                   armed_d;
  logic [SYNC_STAGES-1:0] sync_q;

  always_comb begin
    armed_d = armed_q;
    if (diff_code >= ENTER_V)     armed_d = 1'b1;
    else if (diff_code <= EXIT_V) armed_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  generate
    genvar s;
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= armed_q;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign test_mode = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/prot_out_ctrl.sv
module prot_out_ctrl
  import prot_pkg::*;
#(
  parameter int DIFF_W      = 8,
  parameter int ENTER_CODE  = 125,
  parameter int EXIT_CODE   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ov_flt,
  input  logic              uv_flt,
  input  logic              ow_flt,
  input  logic              ot_flt,
  input  logic              osc_flt,
  input  logic              pol_high_cfg,
  input  logic              latch_cfg,
  input  logic [DIFF_W-1:0] sup_diff_code,
  output logic              chg_pin,
  output logic              chg_oe,
  output logic              dsg_pin,
  output logic              dsg_oe,
  output logic              fault_mode,
  output logic              test_mode
);
  flt_t               flags;
  logic [NUM_OUT-1:0] req;
  logic [NUM_OUT-1:0] act;
  logic [NUM_OUT-1:0] pin;
  logic [NUM_OUT-1:0] oe;
  logic               cfg_high_q;
  logic               cfg_latch_q;

  // Configuration is captured while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_high_q  <= pol_high_cfg;
      cfg_latch_q <= latch_cfg;
    end
  end

  assign flags = '{ov: ov_flt, uv: uv_flt, ow: ow_flt, ot: ot_flt, osc: osc_flt};

  prot_fault_map u_map (
    .flags (flags),
    .req   (req)
  );

  generate
    genvar k;
    for (k = 0; k < NUM_OUT; k++) begin : g_out
      prot_out_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req[k]),
        .latch_en (cfg_latch_q),
        .act_high (cfg_high_q),
        .active   (act[k]),
        .pin      (pin[k]),
        .oe       (oe[k])
      );
    end
  endgenerate

  prot_ctm_detect #(
    .DIFF_W      (DIFF_W),
    .ENTER_CODE  (ENTER_CODE),
    .EXIT_CODE   (EXIT_CODE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctm (
    .clk       (clk),
    .rst_n     (rst_n),
    .diff_code (sup_diff_code),
    .test_mode (test_mode)
  );

  assign chg_pin    = pin[CHG_IDX];
  assign chg_oe     = oe[CHG_IDX];
  assign dsg_pin    = pin[DSG_IDX];
  assign dsg_oe     = oe[DSG_IDX];
  assign fault_mode = |act;
endmodule

// File: rtl/prot_out_ctrl_chk.sv
module prot_out_ctrl_chk #(
  parameter int DIFF_W     = 8,
  parameter int ENTER_CODE = 125
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ov_flt,
  input logic              uv_flt,
  input logic              ow_flt,
  input logic              ot_flt,
  input logic              osc_flt,
  input logic              cfg_high,
  input logic              cfg_latch,
  input logic [DIFF_W-1:0] sup_diff_code,
  input logic              chg_pin,
  input logic              chg_oe,
  input logic              dsg_pin,
  input logic              dsg_oe,
  input logic              fault_mode,
  input logic              test_mode
);
  logic chg_on;
  logic dsg_on;
  assign chg_on = chg_oe & (chg_pin == cfg_high);
  assign dsg_on = dsg_oe & (dsg_pin == cfg_high);

  // R1
  ov_to_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flt |=> chg_on);
  // R2
  uv_to_dsg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flt |=> dsg_on);
  // R3
  shared_to_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ow_flt | ot_flt | osc_flt) |=> (chg_on & dsg_on));
  // R4
  chg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_latch & !ov_flt & !ow_flt & !ot_flt & !osc_flt) |=> !chg_on);
  // R5
  chg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch & chg_on) |=> chg_on);
  // R7
  low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_high |-> (chg_oe == !chg_pin) && (dsg_oe == !dsg_pin));
  // R6
  high_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_high |-> (chg_oe & dsg_oe));
  // R9
  mode_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_mode == (chg_on | dsg_on));
  // R10
  ctm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> ($past(sup_diff_code, 3) >= DIFF_W'(ENTER_CODE)));
endmodule

bind prot_out_ctrl prot_out_ctrl_chk #(
  .DIFF_W     (DIFF_W),
  .ENTER_CODE (ENTER_CODE)
) chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ov_flt        (ov_flt),
  .uv_flt        (uv_flt),
  .ow_flt        (ow_flt),
  .ot_flt        (ot_flt),
  .osc_flt       (osc_flt),
  .cfg_high      (cfg_high_q),
  .cfg_latch     (cfg_latch_q),
  .sup_diff_code (sup_diff_code),
  .chg_pin       (chg_pin),
  .chg_oe        (chg_oe),
  .dsg_pin       (dsg_pin),
  .dsg_oe        (dsg_oe),
  .fault_mode    (fault_mode),
  .test_mode     (test_mode)
);

// File: tb/prot_out_ctrl_test.sv
module prot_out_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ov_flt = 0, uv_flt = 0, ow_flt = 0, ot_flt = 0, osc_flt = 0;
  logic       pol_high_cfg = 1'b1, latch_cfg = 1'b0;
  logic [7:0] sup_diff_code = 8'd0;
  logic       chg_pin, chg_oe, dsg_pin, dsg_oe, fault_mode, test_mode;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R11";
  bit    done = 0;

  // reference model state
  bit m_high, m_latch, m_chg, m_dsg, m_arm;
  bit m_sync[$];

  always #5 clk = ~clk;

  prot_out_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ov_flt(ov_flt), .uv_flt(uv_flt),
    .ow_flt(ow_flt), .ot_flt(ot_flt), .osc_flt(osc_flt),
    .pol_high_cfg(pol_high_cfg), .latch_cfg(latch_cfg),
    .sup_diff_code(sup_diff_code), .chg_pin(chg_pin), .chg_oe(chg_oe),
    .dsg_pin(dsg_pin), .dsg_oe(dsg_oe), .fault_mode(fault_mode),
    .test_mode(test_mode)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // model update and per-cycle comparison
  always @(posedge clk) begin
    bit cr, dr;
    if (!rst_n) begin
      m_high = pol_high_cfg; m_latch = latch_cfg;
      m_chg = 0; m_dsg = 0; m_arm = 0;
      m_sync = '{0, 0};
    end else begin
      cr = ov_flt | ow_flt | ot_flt | osc_flt;
      dr = uv_flt | ow_flt | ot_flt | osc_flt;
      m_chg = m_latch ? (m_chg | cr) : cr;
      m_dsg = m_latch ? (m_dsg | dr) : dr;
      m_sync.push_back(m_arm);
      void'(m_sync.pop_front());
      if (sup_diff_code >= 125) m_arm = 1;
      else if (sup_diff_code <= 100) m_arm = 0;
    end
    #2;
    if (m_sync.size() == 2 && !done) begin
      check(cur_req, "chg_pin", chg_pin, m_high ? m_chg : !m_chg);
      check(cur_req, "chg_oe", chg_oe, m_high ? 1 : m_chg);
      check(cur_req, "dsg_pin", dsg_pin, m_high ? m_dsg : !m_dsg);
      check(cur_req, "dsg_oe", dsg_oe, m_high ? 1 : m_dsg);
      check(cur_req == "R10" ? "R10" : "R9", "fault_mode", fault_mode, m_chg | m_dsg);
      check("R10", "test_mode", test_mode, m_sync[0]);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit pol, bit lat);
    @(negedge clk);
    pol_high_cfg = pol; latch_cfg = lat; rst_n = 0;
    {ov_flt, uv_flt, ow_flt, ot_flt, osc_flt} = '0;
    cyc(2);
    rst_n = 1;
  endtask

  initial begin
    m_sync = '{};
    do_reset(1, 0);
    cur_req = "R11"; cyc(2);
    check("R11", "reset chg_pin", chg_pin, 0);
    check("R11", "reset test_mode", test_mode, 0);

    cur_req = "R1"; ov_flt = 1; cyc(1);
    check("R1", "ov chg_pin", chg_pin, 1);
    check("R1", "ov dsg_pin", dsg_pin, 0);
    cyc(2); ov_flt = 0; cur_req = "R4"; cyc(1);
    check("R4", "ov released chg_pin", chg_pin, 0);

    cur_req = "R2"; uv_flt = 1; cyc(1);
    check("R2", "uv dsg_pin", dsg_pin, 1);
    check("R2", "uv chg_pin", chg_pin, 0);
    uv_flt = 0; cyc(2);

    cur_req = "R3"; ow_flt = 1; cyc(1); ow_flt = 0; cyc(1);
    ot_flt = 1; cyc(1);
    check("R3", "ot both", chg_pin & dsg_pin, 1);
    ot_flt = 0; osc_flt = 1; cyc(3);
    check("R3", "osc both", chg_pin & dsg_pin, 1);
    cur_req = "R4"; osc_flt = 0; cyc(1);
    check("R4", "osc self-clear", chg_pin | dsg_pin, 0);
    check("R9", "normal mode", fault_mode, 0);

    cur_req = "R10"; sup_diff_code = 130; cyc(2);
    check("R10", "not yet armed", test_mode, 0);
    cyc(1);
    check("R10", "entered", test_mode, 1);
    sup_diff_code = 110; cyc(5);
    check("R10", "band keeps on", test_mode, 1);
    sup_diff_code = 100; cyc(3);
    check("R10", "exited", test_mode, 0);
    sup_diff_code = 124; cyc(5);
    check("R10", "band keeps off", test_mode, 0);
    sup_diff_code = 125; cyc(3);
    check("R10", "entered at level", test_mode, 1);
    sup_diff_code = 0; cyc(4);

    cur_req = "R8"; pol_high_cfg = 0; latch_cfg = 1; cyc(2);
    ov_flt = 1; cyc(1); ov_flt = 0; cyc(2);
    check("R8", "cfg ignored chg_pin", chg_pin, 0);
    check("R8", "cfg ignored chg_oe", chg_oe, 1);

    do_reset(0, 1);
    cur_req = "R7"; cyc(2);
    check("R7", "released chg_oe", chg_oe, 0);
    check("R7", "released chg_pin", chg_pin, 1);
    cur_req = "R5"; ov_flt = 1; cyc(1); ov_flt = 0; cyc(6);
    check("R5", "latched chg_oe", chg_oe, 1);
    check("R5", "latched chg_pin", chg_pin, 0);
    check("R5", "dsg still released", dsg_oe, 0);
    uv_flt = 1; cyc(1); uv_flt = 0; cyc(4);
    check("R5", "dsg latched", dsg_oe, 1);
    do_reset(1, 0);
    cur_req = "R11"; cyc(2);
    check("R11", "latch cleared by reset", fault_mode, 0);
    cyc(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule